// File: doc/BRIEF.md
# Touchscreen ADC SPI Responder

This block models the device side of a touchscreen digitizer converter on an SPI link, one byte at a time. A host-side controller delivers each received byte with a single-cycle strobe. The block answers every transfer with exactly one response byte. A byte whose most significant bit is set is a command. It names one of eight measurement channels, and the block captures that channel's 12-bit value at once.

The next two responses carry the captured value, split 7 then 5 bits. After that the block returns zero bytes until the next command arrives. A command that lands in the middle of a result is still answered with the old sequence. It then starts a fresh one.

Channel values come from a packed input bus, or from a fixed set of constants when `FIXED_RESULTS` is set. The controller may also be reconfigured through a write strobe that carries a chip-select-hold flag. If hold was off before that write, the active command is dropped.

Top module: `tsc_spi_responder`

## Requirements
- R1: After reset `tx_byte_o` is 0x00, `tx_valid_o` is 0 and no command is active.
- R2: While no command is active, every transfer is answered with 0x00. This includes the answer to a command byte that arrives while idle.
- R3: A received byte with bit 7 set becomes the active command, and bits 6:4 select the channel. Channel codes: 0 temperature A, 1 Y position, 2 battery, 3 pressure Z1, 4 pressure Z2, 5 X position, 6 microphone, 7 temperature B. Bits 3:0 are ignored. A byte with bit 7 clear does not change the active command.
- R4: The first answer after a command is `{1'b0, result[11:5]}`.
- R5: The second answer after a command is `{result[4:0], 3'b000}`.
- R6: Every later answer is 0x00 until a new command arrives.
- R7: A command arriving before both result bytes are out is answered from the old sequence. The new result then starts from its first byte.
- R8: The channel value is captured in the cycle the command is accepted. Later changes on `chan_data_i` do not alter either result byte.
- R9: With `FIXED_RESULTS=1`, channel 5 (X) reads 0x000, channel 1 (Y) reads 0xFFF and all other channels read 0x000, whatever `chan_data_i` holds.
- R10: A `cfg_we_i` strobe clears the active command if the hold flag stored by the previous strobe (0 after reset) was 0. The strobe then stores `cfg_hold_i`. If `cfg_we_i` and a command byte arrive in the same cycle, the clear wins.
- R11: `tx_valid_o` is high for exactly the one cycle after each `rx_valid_i` cycle.
- R12: `tx_byte_o` holds its value between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte_i | input | 8 | Received byte |
| cfg_we_i | input | 1 | Controller reconfiguration strobe |
| cfg_hold_i | input | 1 | Chip-select hold flag carried by the strobe |
| chan_data_i | input | 96 | Channel values, channel k at bits [12k+11:12k] |
| tx_valid_o | output | 1 | Response byte updated this cycle |
| tx_byte_o | output | 8 | Response byte for the latest transfer |

## Verification
Each response byte is registered once, so it appears one clock after the `rx_valid_i` cycle that asked for it, together with a one-cycle `tx_valid_o`. The bench drives a transfer on a falling edge and samples the answer on the next falling edge. The result bytes, the padding and the restart cases therefore all fall on the first sample after their request.

A configuration strobe only takes effect for the transfer that follows it. Its outcome is therefore judged through the answer to the next transfer rather than at the strobe itself. Values captured at a command are tested by changing the channel inputs after the command and before its result bytes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RES_W  = 12;
  localparam int unsigned N_CHAN = 8;
  localparam int unsigned CHAN_W = $clog2(N_CHAN);

  typedef enum logic [CHAN_W-1:0] {
    CH_TEMP_A = 3'd0,
    CH_YPOS   = 3'd1,
    CH_BATT   = 3'd2,
    CH_PRS_Z1 = 3'd3,
    CH_PRS_Z2 = 3'd4,
    CH_XPOS   = 3'd5,
    CH_MIC    = 3'd6,
    CH_TEMP_B = 3'd7
  } chan_e;

  typedef enum logic [1:0] {
    PH_HI  = 2'd0,
    PH_LO  = 2'd1,
    PH_PAD = 2'd2
  } phase_e;
endpackage

// File: rtl/tsc_cmd_latch.sv
module tsc_cmd_latch #(
  parameter int unsigned BYTE_W = tsc_pkg::BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              cfg_we_i,
  input  logic              cfg_hold_i,
  output logic              accept_o,
  output logic              cmd_valid_o
);
  logic hold_q;
  logic clear;

  assign accept_o = rx_valid_i && rx_byte_i[BYTE_W-1];
  assign clear    = cfg_we_i && !hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= 1'b0;
      cmd_valid_o <= 1'b0;
    end else begin
      if (cfg_we_i) hold_q <= cfg_hold_i;
      if (clear)         cmd_valid_o <= 1'b0;
      else if (accept_o) cmd_valid_o <= 1'b1;
    end
  end

  logic unused_low_bits;
  assign unused_low_bits = ^rx_byte_i[BYTE_W-2:0];
endmodule

// File: rtl/tsc_chan_select.sv
module tsc_chan_select #(
  parameter int unsigned RES_W         = tsc_pkg::RES_W,
  parameter int unsigned N_CHAN        = tsc_pkg::N_CHAN,
  parameter bit          FIXED_RESULTS = 1'b0,
  localparam int unsigned CHAN_W       = $clog2(N_CHAN)
) (
  input  logic [CHAN_W-1:0]       sel_i,
  input  logic [N_CHAN*RES_W-1:0] chan_data_i,
  output logic [RES_W-1:0]        result_o
);
  import tsc_pkg::*;

  generate
    if (FIXED_RESULTS) begin : g_fixed
      always_comb begin
        result_o = '0;
        if (sel_i == CH_YPOS) result_o = '1;
      end
      logic unused_data;
      assign unused_data = ^chan_data_i;
    end else begin : g_ports
      assign result_o = chan_data_i[sel_i*RES_W +: RES_W];
    end
  endgenerate
endmodule

// File: rtl/tsc_frame.sv
module tsc_frame #(
  parameter int unsigned BYTE_W = tsc_pkg::BYTE_W,
  parameter int unsigned RES_W  = tsc_pkg::RES_W,
  localparam int unsigned HI_W  = BYTE_W - 1,
  localparam int unsigned LO_W  = RES_W - HI_W,
  localparam int unsigned SH_W  = BYTE_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              accept_i,
  input  logic              cmd_valid_i,
  input  logic [RES_W-1:0]  sample_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  import tsc_pkg::*;

  phase_e           phase_q;
  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_PAD;
      res_q      <= '0;
      tx_valid_o <= 1'b0;
      tx_byte_o  <= '0;
    end else begin
      tx_valid_o <= rx_valid_i;
      if (rx_valid_i) begin
        // answer from the state before this byte
        if (!cmd_valid_i) begin
          tx_byte_o <= '0;
        end else begin
          unique case (phase_q)
            PH_HI: begin
              tx_byte_o <= {1'b0, res_q[RES_W-1:LO_W]};
              phase_q   <= PH_LO;
            end
            PH_LO: begin
              tx_byte_o <= {res_q[LO_W-1:0], {SH_W{1'b0}}};
              phase_q   <= PH_PAD;
            end
            default: tx_byte_o <= '0;
          endcase
        end
        if (accept_i) begin
          res_q   <= sample_i;
          phase_q <= PH_HI;
        end
      end
    end
  end
endmodule

// File: rtl/tsc_spi_responder.sv
module tsc_spi_responder #(
  parameter int unsigned BYTE_W        = tsc_pkg::BYTE_W,
  parameter int unsigned RES_W         = tsc_pkg::RES_W,
  parameter int unsigned N_CHAN        = tsc_pkg::N_CHAN,
  parameter bit          FIXED_RESULTS = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rx_valid_i,
  input  logic [BYTE_W-1:0]       rx_byte_i,
  input  logic                    cfg_we_i,
  input  logic                    cfg_hold_i,
  input  logic [N_CHAN*RES_W-1:0] chan_data_i,
  output logic                    tx_valid_o,
  output logic [BYTE_W-1:0]       tx_byte_o
);
  localparam int unsigned CHAN_W = $clog2(N_CHAN);

  logic             accept;
  logic             cmd_valid;
  logic [RES_W-1:0] sample;

  tsc_cmd_latch #(.BYTE_W(BYTE_W)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_hold_i (cfg_hold_i),
    .accept_o   (accept),
    .cmd_valid_o(cmd_valid)
  );

  tsc_chan_select #(
    .RES_W(RES_W), .N_CHAN(N_CHAN), .FIXED_RESULTS(FIXED_RESULTS)
  ) u_sel (
    .sel_i      (rx_byte_i[BYTE_W-2 -: CHAN_W]),
    .chan_data_i(chan_data_i),
    .result_o   (sample)
  );

  tsc_frame #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .accept_i   (accept),
    .cmd_valid_i(cmd_valid),
    .sample_i   (sample),
    .tx_valid_o (tx_valid_o),
    .tx_byte_o  (tx_byte_o)
  );
endmodule

// File: rtl/tsc_spi_responder_chk.sv
module tsc_spi_responder_chk #(
  parameter int unsigned BYTE_W = tsc_pkg::BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic [BYTE_W-1:0] rx_byte_i,
  input logic              cfg_we_i,
  input logic              cfg_hold_i,
  input logic              tx_valid_o,
  input logic [BYTE_W-1:0] tx_byte_o
);
  // independent view: position of next answer after a command (1,2,3=pad)
  logic       m_cmd, m_hold;
  logic [1:0] m_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cmd  <= 1'b0;
      m_hold <= 1'b0;
      m_pos  <= 2'd3;
    end else begin
      if (cfg_we_i) m_hold <= cfg_hold_i;
      if (cfg_we_i && !m_hold) m_cmd <= 1'b0;
      else if (rx_valid_i && rx_byte_i[BYTE_W-1]) m_cmd <= 1'b1;
      if (rx_valid_i) begin
        if (rx_byte_i[BYTE_W-1]) m_pos <= 2'd1;
        else if (m_pos != 2'd3)  m_pos <= m_pos + 2'd1;
      end
    end
  end

  assert_valid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> tx_valid_o);
  assert_valid_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !tx_valid_o);
  assert_byte_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> $stable(tx_byte_o));
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !m_cmd) |=> (tx_byte_o == '0));
  assert_first_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && m_cmd && m_pos == 2'd1) |=> !tx_byte_o[BYTE_W-1]);
  assert_second_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && m_cmd && m_pos == 2'd2) |=> (tx_byte_o[2:0] == 3'b000));
  assert_pad_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && m_pos == 2'd3) |=> (tx_byte_o == '0));
endmodule

bind tsc_spi_responder tsc_spi_responder_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
  .cfg_we_i(cfg_we_i), .cfg_hold_i(cfg_hold_i),
  .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o)
);

// File: tb/test_tsc_spi_responder.sv
`timescale 1ns/1ps
module test_tsc_spi_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_hold = 1'b0;
  logic [95:0] chan_data;
  logic [95:0] ones = '1;
  logic        tx_valid, tx_valid_f;
  logic [7:0]  tx_byte, tx_byte_f;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tsc_spi_responder i_tsc_spi_responder (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .cfg_we_i(cfg_we), .cfg_hold_i(cfg_hold), .chan_data_i(chan_data),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte));

  tsc_spi_responder #(.FIXED_RESULTS(1'b1)) i_tsc_spi_responder_fixed (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .cfg_we_i(cfg_we), .cfg_hold_i(cfg_hold), .chan_data_i(ones),
    .tx_valid_o(tx_valid_f), .tx_byte_o(tx_byte_f));

  // ch0=001 ch1(Y)=ABC ch3=FFF ch5(X)=3E7
  localparam logic [11:0] CH0 = 12'h001, CH1 = 12'hABC, CH3 = 12'hFFF, CH5 = 12'h3E7;

  // {rx byte, expected answer}
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    16'h00_00,  // R2 idle
    16'h90_00,  // R2 command while idle -> 0, select Y (R3)
    16'h00_55,  // R4 ABC[11:5]
    16'h00_E0,  // R5 ABC[4:0]<<3
    16'h00_00,  // R6 pad
    16'h12_00,  // R3 no start bit, R6 still pad
    16'hD3_00,  // R3 select X, low nibble ignored
    16'h00_1F,  // R4 3E7[11:5]
    16'hB0_38,  // R7 new command while second byte due
    16'h00_7F,  // R4 FFF hi
    16'h80_F8,  // R7 answer from old, restart on ch0
    16'h90_00,  // R7 restart after first byte only (ch0 hi = 00)
    16'h00_55,  // R7 new sequence first byte
    16'h00_E0,  // R5
    16'h00_00   // R6
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0; rx_byte = '0;
  endtask

  task automatic cfg(input logic h);
    @(negedge clk);
    cfg_we = 1'b1; cfg_hold = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    chan_data = '0;
    chan_data[0*12 +: 12] = CH0;
    chan_data[1*12 +: 12] = CH1;
    chan_data[3*12 +: 12] = CH3;
    chan_data[5*12 +: 12] = CH5;
    repeat (3) @(negedge clk);
    chk("R1 reset byte", tx_byte, 8'h00);
    chk("R1 reset valid", {7'b0, tx_valid}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][15:8]);
      chk($sformatf("R4/R5/R6/R7 vector %0d", i), tx_byte, VEC[i][7:0]);
      chk("R11 valid high", {7'b0, tx_valid}, 8'h01);
    end

    // R11 pulse width, R12 hold
    xfer(8'h90);
    xfer(8'h00);
    @(negedge clk);
    chk("R11 valid single", {7'b0, tx_valid}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R12 byte held", tx_byte, 8'h55);

    // R8 capture at command
    xfer(8'hB0);
    chan_data[3*12 +: 12] = 12'h000;
    xfer(8'h00); chk("R8 hi from capture", tx_byte, 8'h7F);
    chan_data[3*12 +: 12] = 12'h555;
    xfer(8'h00); chk("R8 lo from capture", tx_byte, 8'hF8);
    chan_data[3*12 +: 12] = CH3;

    // R10 hold behaviour
    cfg(1'b1);                 // stored hold was 0 -> clears
    xfer(8'h00); chk("R10 clear on unheld cfg", tx_byte, 8'h00);
    xfer(8'h90);
    cfg(1'b0);                 // stored hold was 1 -> kept
    xfer(8'h00); chk("R10 kept under hold", tx_byte, 8'h55);
    cfg(1'b0);                 // stored hold 0 -> clears
    xfer(8'h00); chk("R10 cleared mid result", tx_byte, 8'h00);
    xfer(8'h00); chk("R10 stays idle", tx_byte, 8'h00);

    // R10 clear wins over simultaneous command
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = 8'h90; cfg_we = 1'b1; cfg_hold = 1'b0;
    @(negedge clk);
    rx_valid = 1'b0; rx_byte = '0; cfg_we = 1'b0;
    xfer(8'h00); chk("R10 clear beats command", tx_byte, 8'h00);

    // R9 fixed channel values
    for (int c = 0; c < 8; c++) begin
      xfer({1'b1, c[2:0], 4'h0});
      chk($sformatf("R9 ch%0d cmd answer", c), tx_byte_f, 8'h00);
      xfer(8'h00);
      chk($sformatf("R9 ch%0d hi", c), tx_byte_f, (c == 1) ? 8'h7F : 8'h00);
      xfer(8'h00);
      chk($sformatf("R9 ch%0d lo", c), tx_byte_f, (c == 1) ? 8'hF8 : 8'h00);
    end

    finish_run();
  end
endmodule